// File: doc/BRIEF.md
# Serial Configuration Loader with Latched Register Select

This block receives configuration words over a three-wire serial link (serial clock, serial data, latch enable) and places each word into one of four parallel configuration registers. While latch enable is low, every rising edge of the serial clock moves one data bit into a 20-bit holding shift register, most significant bit first. When latch enable rises, the holding word is transferred. Its two lowest bits, which are the last bits shifted in, pick the destination register. Its upper 18 bits become that register's new contents.

All three serial pins are asynchronous to the system clock, so they are synchronised into the system clock domain before use. The serial clock may keep toggling while latch enable is high; those edges do not disturb the holding word. Each transfer produces a one-cycle load strobe for the register that was written. Downstream logic, such as a divider that must restart on new settings, can use that strobe to resynchronise.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is asserted and after its release, all four registers read zero and no load strobe is active until the first transfer.
- R2: While latch enable is low, each rising serial clock edge shifts the serial data bit into the low end of the 20-bit holding register, so the first bit sent ends up as bit 19.
- R3: On a transfer, holding bits [1:0] select the destination register, with value 0 selecting register 0 (cfg_q bits [17:0]) through value 3 selecting register 3 (cfg_q bits [71:54]).
- R4: The destination register receives holding bits [19:2]; the address bits are not stored.
- R5: Each rising edge of latch enable produces exactly one single-cycle strobe on cfg_load, on the bit of the addressed register, in the same cycle that the register shows its new value.
- R6: Serial clock edges that occur while latch enable is high do not change the holding register.
- R7: If more or fewer than 20 serial clocks occur between transfers, the transfer uses the last 20 bits shifted, including bits left over from earlier words.
- R8: Registers that are not addressed by a transfer keep their values, and at most one strobe bit is active in any cycle.
- R9: A latch enable high pulse lasting a single system clock cycle completes a transfer.
- R10: A serial clock that keeps running through the latch pulse does not corrupt the transferred word or the words that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Serial clock; asynchronous to clk |
| ser_data | input | 1 | Serial data, sampled on the rising edge of ser_clk |
| ser_latch | input | 1 | Latch enable; low to shift, rising edge to transfer |
| cfg_q | output | 72 | Four 18-bit registers concatenated, register 0 in the lowest bits |
| cfg_load | output | 4 | One-cycle load strobe, one bit per register |

## Verification
The bench toggles the serial clock while latch enable is high and then sends only a short tail before the next transfer. A design that shifts during the latch would deliver a word containing those ignored bits. Short and overlong bursts check the keep-the-last-20-bits rule: a design that cleared the holding word after each transfer, or counted bits, would store the wrong payload. A one-cycle latch pulse and writes to every address catch a missed edge, a swapped address decode, and a payload that still carries the address bits. Every strobe is matched against a queue of expected transfers, so a strobe that lasts two cycles, appears without a transfer or goes missing is reported.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned CFG_WORD_W  = 20;
  localparam int unsigned CFG_ADDR_W  = 2;
  localparam int unsigned CFG_SYNC_ST = 2;

  // bit positions of the synchronised pin vector
  localparam int unsigned PIN_SCK = 0;
  localparam int unsigned PIN_SDI = 1;
  localparam int unsigned PIN_LE  = 2;
  localparam int unsigned PIN_NUM = 3;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_a,
  output logic [WIDTH-1:0] pin_s
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = pin_a;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              le_s,
  output logic [WORD_W-1:0] word,
  output logic              sck_rise,
  output logic              xfer
);
  logic              sck_q, le_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              shift_en;

  assign sck_rise = sck_s & ~sck_q;
  assign xfer     = le_s & ~le_q;
  assign shift_en = sck_rise & ~le_s;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      le_q   <= 1'b0;
      word_q <= '0;
    end else begin
      sck_q  <= sck_s;
      le_q   <= le_s;
      if (shift_en) word_q <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int unsigned WORD_W = 20,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NUM_REGS = 1 << ADDR_W,
  localparam int unsigned PAY_W    = WORD_W - ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xfer,
  input  logic [WORD_W-1:0]         word,
  output logic [NUM_REGS*PAY_W-1:0] cfg_q,
  output logic [NUM_REGS-1:0]       cfg_load
);
  logic [ADDR_W-1:0]   sel;
  logic [PAY_W-1:0]    payload;
  logic [NUM_REGS-1:0] load_d;

  assign sel     = word[ADDR_W-1:0];
  assign payload = word[WORD_W-1:ADDR_W];

  always_comb begin
    load_d = '0;
    if (xfer) load_d[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_load <= '0;
    else        cfg_load <= load_d;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [PAY_W-1:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q <= '0;
      else if (load_d[r]) reg_q <= payload;
    end
    assign cfg_q[r*PAY_W +: PAY_W] = reg_q;
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int unsigned WORD_W      = cfg_serial_pkg::CFG_WORD_W,
  parameter int unsigned ADDR_W      = cfg_serial_pkg::CFG_ADDR_W,
  parameter int unsigned SYNC_STAGES = cfg_serial_pkg::CFG_SYNC_ST,
  localparam int unsigned NUM_REGS = 1 << ADDR_W,
  localparam int unsigned PAY_W    = WORD_W - ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_data,
  input  logic                      ser_latch,
  output logic [NUM_REGS*PAY_W-1:0] cfg_q,
  output logic [NUM_REGS-1:0]       cfg_load
);
  import cfg_serial_pkg::*;

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [PIN_NUM-1:0] pins_a, pins_s;
  logic               le_sync, sck_rise, xfer;
  logic [WORD_W-1:0]  shift_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    pins_a          = '0;
    pins_a[PIN_SCK] = ser_clk;
    pins_a[PIN_SDI] = ser_data;
    pins_a[PIN_LE]  = ser_latch;
  end

  cfg_pin_sync #(.WIDTH(PIN_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_a (pins_a),
    .pin_s (pins_s)
  );

  assign le_sync = pins_s[PIN_LE];

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck_s    (pins_s[PIN_SCK]),
    .sdi_s    (pins_s[PIN_SDI]),
    .le_s     (le_sync),
    .word     (shift_word),
    .sck_rise (sck_rise),
    .xfer     (xfer)
  );

  cfg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .xfer     (xfer),
    .word     (shift_word),
    .cfg_q    (cfg_q),
    .cfg_load (cfg_load)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int unsigned WORD_W = 20,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NUM_REGS = 1 << ADDR_W,
  localparam int unsigned PAY_W    = WORD_W - ADDR_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      le_sync,
  input logic                      sck_rise,
  input logic [WORD_W-1:0]         shift_word,
  input logic [NUM_REGS*PAY_W-1:0] cfg_q,
  input logic [NUM_REGS-1:0]       cfg_load
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_q == '0 && cfg_load == '0));

  assert_shift_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(shift_word));

  assert_frozen_in_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    le_sync |=> $stable(shift_word));

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_load));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load[r] |=> !cfg_load[r]);
    assert_hold_unaddressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load[r] |-> $stable(cfg_q[r*PAY_W +: PAY_W]));
  end
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .le_sync    (le_sync),
  .sck_rise   (sck_rise),
  .shift_word (shift_word),
  .cfg_q      (cfg_q),
  .cfg_load   (cfg_load)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int W = 20;
  localparam int A = 2;
  localparam int NR = 1 << A;
  localparam int PW = W - A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic [NR*PW-1:0] cfg_q;
  logic [NR-1:0]    cfg_load;

  int checks = 0;
  int errors = 0;
  logic [W-1:0]  model_shift = '0;
  logic [PW-1:0] model_bank [NR];
  logic [W-1:0]  exp_q [$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .cfg_q(cfg_q), .cfg_load(cfg_load)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: one serial bit, shifted only when latch enable is low (R6)
  task automatic shift_bit(input logic b);
    @(negedge clk); ser_data = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    if (!ser_latch) model_shift = {model_shift[W-2:0], b};
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
  endtask

  task automatic latch(input int hold);
    repeat (3) @(negedge clk);
    exp_q.push_back(model_shift);
    ser_latch = 1'b1;
    repeat (hold) @(negedge clk);
    ser_latch = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // R10: serial clock keeps toggling while latch enable is high
  task automatic latch_running(input logic [7:0] junk);
    repeat (3) @(negedge clk);
    exp_q.push_back(model_shift);
    ser_latch = 1'b1;
    @(negedge clk);
    send({24'd0, junk}, 8);
    ser_latch = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // monitor: every strobe consumes one expected transfer
  always @(negedge clk) begin
    if (rst_n && !done && cfg_load != '0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 spurious strobe", {28'd0, cfg_load}, 32'd0);
      end else begin
        logic [W-1:0] w;
        logic [A-1:0] ad;
        w  = exp_q.pop_front();
        ad = w[A-1:0];
        model_bank[ad] = w[W-1:A];
        check(cfg_load == (NR'(1) << ad), "R3/R5 strobe select",
              {28'd0, cfg_load}, {28'd0, NR'(1) << ad});
        for (int r = 0; r < NR; r++)
          check(cfg_q[r*PW +: PW] == model_bank[r], "R4/R8 register contents",
                {14'd0, cfg_q[r*PW +: PW]}, {14'd0, model_bank[r]});
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) model_bank[r] = '0;
    repeat (5) @(negedge clk);
    check(cfg_q == '0, "R1 registers clear in reset", cfg_q[31:0], 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(cfg_q == '0, "R1 registers clear after reset", cfg_q[31:0], 32'd0);
    check(cfg_load == '0, "R1 no strobe after reset", {28'd0, cfg_load}, 32'd0);

    // R2 R3 R4: one word to each address
    send(32'hA5C3_0, W); latch(3);
    send(32'h3C5A_5, W); latch(3);
    send(32'hF0F0_A, W); latch(3);
    send(32'h1234_7, W); latch(3);
    // R8: overwrite one register, others hold
    send(32'h7777_6, W); latch(3);
    // R6 R10: clocks during latch ignored, then a short tail of 6 bits
    latch_running(8'hB6);
    send(32'h0000_0032, 6); latch(3);
    // R7: 23 clocks, then 5 clocks
    send(32'h0055_AA9D, 23); latch(3);
    send(32'h0000_0013, 5); latch(3);
    // R9: one-cycle latch pulse
    send(32'h9ABC_D, W); latch(1);
    send(32'h0246_8, W); latch(1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R5 every latch gave a strobe",
          exp_q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule